// File: doc/BRIEF.md
# Cut-Through Packet Forwarding Stage

This block is the forwarding stage for one output link of a node in a direct-link network. Packets enter one word per cycle on a valid/ready stream. Start and end markers frame each packet. The first word of a packet is its head, and it carries the source and destination address fields. The stage does not decode those fields. It passes every word through unchanged, with the same start and end markers.

The stage decides how to handle a packet when the head arrives. If the outgoing link is free, the buffer is empty and forwarding without storage is allowed, the packet streams straight through in the same cycle it is accepted. If the link is blocked, the whole packet is written into an on-chip buffer. It leaves once the link frees. If the link becomes blocked partway through a streaming packet, the rest of that packet goes into the buffer and drains in order later. A mode input forces store-and-forward operation, in which no word of a packet leaves before its last word has been stored.

The buffer is sized by parameters from the maximum payload in bytes, the word width and the number of head words. A new packet is only admitted into the buffer when a full maximum-size packet fits.

Top module: `ct_forwarder`

## Requirements
- R1: After synchronous reset, `out_valid` is low, the buffer holds nothing, and `in_ready` is high while `link_busy` is low and `out_ready` is high.
- R2: When `fwd_saf` is low, the buffer is empty, `link_busy` is low and `out_ready` is high as a head word is accepted, that word and each later word of the packet appear on the output in the same cycle they are accepted, as long as the link stays free.
- R3: A head that arrives while `link_busy` is high is accepted into the buffer when room allows, together with the rest of its packet. The packet is forwarded intact once `link_busy` falls.
- R4: `out_valid` is never high in a cycle where `link_busy` is high.
- R5: When `fwd_saf` is high, no word of a packet appears on the output before that packet's end word (`in_eop` = 1) has been accepted. This holds even when the link is free.
- R6: If a packet starts streaming through and the link becomes unavailable before its end word, the remaining words are written to the buffer without stalling the input. They leave after the words already sent, in order.
- R7: `in_ready` is low for a head word that is not streamed through when fewer than MAX_PKT_WORDS buffer entries are free. MAX_PKT_WORDS is ceil(MAX_PAYLOAD_BYTES / (DATA_W/8)) + HEAD_WORDS. Once a head is accepted, `in_ready` stays high for the rest of that packet.
- R8: A head that arrives while earlier words are still in the buffer is itself buffered and never overtakes them. Packet order is the order of acceptance.
- R9: Every word leaves with the data and the `sop`/`eop` markers it entered with, including single-word packets (`in_sop` = `in_eop` = 1) and under output backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_saf | input | 1 | 1 = store-and-forward only; 0 = cut-through allowed |
| link_busy | input | 1 | Outgoing link is reserved by other traffic |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | DATA_W | Input word; the head word holds the address fields |
| in_sop | input | 1 | Marks the head word |
| in_eop | input | 1 | Marks the last word |
| out_valid | output | 1 | Output word valid (may depend on `out_ready` on the streaming path) |
| out_ready | input | 1 | Downstream takes the word when high with `out_valid` |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | Head marker of the output word |
| out_eop | output | 1 | End marker of the output word |

## Verification
A wrong path decision shows up on the ports immediately. A head that should stream through but is buffered appears a cycle late or more. A head that overtakes buffered words reaches the output ahead of older data in the same cycle it is accepted. A drifting buffer pointer or count shows up as a wrong or repeated word at the next drained position. A packet-count error in store-and-forward mode either releases words before their end word arrives or stalls the output for good. Both are visible within one packet time.

// File: rtl/ct_fwd_pkg.sv
package ct_fwd_pkg;

  // Handling of the packet currently entering the stage
  typedef enum logic [1:0] {
    PATH_IDLE = 2'd0,  // between packets, next word is a head
    PATH_CUT  = 2'd1,  // streaming straight to the output
    PATH_BUF  = 2'd2   // words go into the buffer
  } path_e;

  // Ceiling division used to turn a byte limit into a word limit
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/ct_word_buffer.sv
module ct_word_buffer #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  // storage array without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

endmodule

// File: rtl/ct_pkt_tally.sv
module ct_pkt_tally #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count
);

  // number of complete packets (end word stored) held in the buffer
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CW'(inc) - CW'(dec);
  end

endmodule

// File: rtl/ct_path_ctrl.sv
module ct_path_ctrl
  import ct_fwd_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int PKT_WORDS = 251,
  parameter int CW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_saf,
  input  logic          link_busy,
  input  logic          out_ready,
  input  logic          in_valid,
  input  logic          in_eop,
  input  logic [CW-1:0] buf_count,
  input  logic [CW-1:0] pkt_count,
  output logic          in_ready,
  output logic          pass_en,
  output logic          wr_en,
  output logic          rd_en,
  output logic          drain_ok
);

  path_e path_q, path_d;

  logic link_ok;
  logic buf_empty;
  logic [CW-1:0] buf_free;
  logic head_cut;
  logic head_room;

  assign link_ok   = !link_busy && out_ready;
  assign buf_empty = (buf_count == '0);
  assign buf_free  = CW'(DEPTH) - buf_count;
  assign head_cut  = !fwd_saf && buf_empty && link_ok;
  assign head_room = (buf_free >= CW'(PKT_WORDS));

  always_comb begin
    in_ready = 1'b1;
    pass_en  = 1'b0;
    unique case (path_q)
      PATH_IDLE: begin
        in_ready = head_cut || head_room;
        pass_en  = in_valid && head_cut;
      end
      PATH_CUT: pass_en = in_valid && link_ok;
      default:  pass_en = 1'b0;
    endcase
  end

  assign wr_en    = in_valid && in_ready && !pass_en;
  assign drain_ok = !buf_empty && (!fwd_saf || (pkt_count != '0));
  assign rd_en    = drain_ok && link_ok;

  always_comb begin
    path_d = path_q;
    unique case (path_q)
      PATH_IDLE: begin
        if (in_valid && in_ready && !in_eop)
          path_d = pass_en ? PATH_CUT : PATH_BUF;
      end
      PATH_CUT: begin
        if (in_valid) begin
          if (in_eop)        path_d = PATH_IDLE;
          else if (!link_ok) path_d = PATH_BUF;
        end
      end
      default: begin
        if (in_valid && in_eop) path_d = PATH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) path_q <= PATH_IDLE;
    else     path_q <= path_d;
  end

endmodule

// File: rtl/ct_forwarder.sv
module ct_forwarder #(
  parameter int DATA_W            = 32,
  parameter int MAX_PAYLOAD_BYTES = 1000,
  parameter int HEAD_WORDS        = 1,
  parameter int BUF_DEPTH         = 256,
  localparam int WORD_BYTES    = DATA_W / 8,
  localparam int MAX_PKT_WORDS = ct_fwd_pkg::ceil_div(MAX_PAYLOAD_BYTES, WORD_BYTES) + HEAD_WORDS,
  localparam int CNT_W         = $clog2(BUF_DEPTH + 1),
  localparam int ENTRY_W       = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd_saf,
  input  logic              link_busy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  logic               pass_en;
  logic               wr_en;
  logic               rd_en;
  logic               drain_ok;
  logic [CNT_W-1:0]   buf_count;
  logic [CNT_W-1:0]   pkt_count;
  logic [ENTRY_W-1:0] wr_entry;
  logic [ENTRY_W-1:0] rd_entry;

  assign wr_entry = {in_sop, in_eop, in_data};

  ct_path_ctrl #(
    .DEPTH     (BUF_DEPTH),
    .PKT_WORDS (MAX_PKT_WORDS),
    .CW        (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fwd_saf   (fwd_saf),
    .link_busy (link_busy),
    .out_ready (out_ready),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .buf_count (buf_count),
    .pkt_count (pkt_count),
    .in_ready  (in_ready),
    .pass_en   (pass_en),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .drain_ok  (drain_ok)
  );

  ct_word_buffer #(
    .WIDTH (ENTRY_W),
    .DEPTH (BUF_DEPTH)
  ) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_entry),
    .rd_en   (rd_en),
    .rd_data (rd_entry),
    .count   (buf_count)
  );

  ct_pkt_tally #(
    .CW (CNT_W)
  ) u_tally (
    .clk   (clk),
    .rst   (rst),
    .inc   (wr_en && in_eop),
    .dec   (rd_en && rd_entry[DATA_W]),
    .count (pkt_count)
  );

  // streaming path and buffer path never drive the output in the same cycle
  assign out_valid = pass_en || (drain_ok && !link_busy);
  assign {out_sop, out_eop, out_data} = pass_en ? wr_entry : rd_entry;

endmodule

// File: rtl/ct_forwarder_chk.sv
module ct_forwarder_chk #(
  parameter int BUF_DEPTH = 256,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             fwd_saf,
  input logic             link_busy,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_eop,
  input logic             out_valid,
  input logic             wr_en,
  input logic [CNT_W-1:0] buf_count,
  input logic [CNT_W-1:0] pkt_count
);

  // R4: nothing offered while the link is reserved
  p_quiet_busy_r4: assert property (@(posedge clk) disable iff (rst)
    link_busy |-> !out_valid);

  // R7: a buffer write never lands on a full buffer
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (buf_count < CNT_W'(BUF_DEPTH)));

  // R7: the body of an accepted packet is never stalled
  p_body_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_eop) |=> in_ready);

  // R5: store-and-forward output only while a complete packet is held
  p_saf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fwd_saf && out_valid) |-> (pkt_count != '0));

  // R5: a word taken in store-and-forward mode is held in the buffer
  p_saf_store_r5: assert property (@(posedge clk) disable iff (rst)
    (fwd_saf && in_valid && in_ready) |=> (buf_count != '0));

  // R3: complete packets never outnumber stored words
  p_tally_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pkt_count <= buf_count);

endmodule

bind ct_forwarder ct_forwarder_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fwd_saf   (fwd_saf),
  .link_busy (link_busy),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eop    (in_eop),
  .out_valid (out_valid),
  .wr_en     (wr_en),
  .buf_count (buf_count),
  .pkt_count (pkt_count)
);

// File: tb/ct_forwarder_tb.sv
module ct_forwarder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int MAX_BYTES  = 16;  // 4 payload words + 1 head = 5 words per packet
  localparam int HEAD_W     = 1;
  localparam int DEPTH      = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwd_saf = 1'b0;
  logic link_busy = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic in_sop = 1'b0;
  logic in_eop = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DATA_W-1:0] out_data;
  logic out_sop;
  logic out_eop;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ct_forwarder #(
    .DATA_W (DATA_W), .MAX_PAYLOAD_BYTES (MAX_BYTES),
    .HEAD_WORDS (HEAD_W), .BUF_DEPTH (DEPTH)
  ) u_dut (
    .clk (clk), .rst (rst), .fwd_saf (fwd_saf), .link_busy (link_busy),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .in_sop (in_sop), .in_eop (in_eop), .out_valid (out_valid),
    .out_ready (out_ready), .out_data (out_data), .out_sop (out_sop),
    .out_eop (out_eop)
  );

  int n_checks = 0;
  int n_fails  = 0;
  string cur_req = "R9";
  logic [DATA_W+1:0] exp_q[$];
  bit cut_watch = 1'b0;
  bit saf_watch = 1'b0;
  bit saf_eop_seen = 1'b0;
  int out_count = 0;
  bit bp_en = 1'b0;
  int bp_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: push accepted words, pop and compare delivered words
  always @(negedge clk) begin
    if (!rst) begin
      if (in_valid && in_ready) begin
        exp_q.push_back({in_sop, in_eop, in_data});
        if (cut_watch)  // R2: same-cycle pass-through
          check(out_valid && out_ready && out_data == in_data, "R2",
                "cut-through word", {31'd0, out_valid, out_data}, {32'd1, in_data});
      end
      if (out_valid && out_ready) begin
        out_count++;
        if (saf_watch)
          check(saf_eop_seen, "R5", "output before end word stored", 64'd1, 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected output word", 64'(out_data), 64'd0);
        end else begin
          logic [DATA_W+1:0] e;
          e = exp_q.pop_front();
          check({out_sop, out_eop, out_data} == e, cur_req, "output word/markers",
                64'({out_sop, out_eop, out_data}), 64'(e));
        end
      end
      if (link_busy)  // R4
        check(!out_valid, "R4", "out_valid while link busy", 64'(out_valid), 64'd0);
      if (saf_watch && in_valid && in_ready && in_eop) saf_eop_seen = 1'b1;
    end
  end

  // output backpressure pattern for R9
  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      out_ready = (bp_cnt % 3 != 2);
      bp_cnt++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_pkt(input int len, input int gap, input int tag, output int stalls);
    stalls = 0;
    for (int i = 0; i < len; i++) begin
      bit acc;
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = (i == 0) ? {16'(tag), 16'(tag ^ 16'h00A5)} : DATA_W'(tag * 256 + i);
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        acc = in_ready;
        if (!acc) stalls++;
        @(posedge clk); #1;
      end
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      if (i < len - 1) repeat (gap) step();
    end
  endtask

  task automatic wait_drain(input string req);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 300) begin step(); n++; end
    check(exp_q.size() == 0, req, "buffer drained", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    int st;
    int snap;
    repeat (3) step();
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    step();

    // R2: streaming, back to back and with gaps
    cur_req = "R2"; cut_watch = 1'b1;
    send_pkt(4, 0, 16'h11, st);
    send_pkt(5, 2, 16'h12, st);
    cut_watch = 1'b0;
    wait_drain("R2");

    // R3/R4: blocked link at head, whole packet buffered
    cur_req = "R3"; link_busy = 1'b1;
    snap = out_count;
    send_pkt(5, 0, 16'h21, st);
    check(st == 0, "R3", "stalls while buffering", 64'(st), 64'd0);
    repeat (4) step();
    check(out_count == snap, "R3", "words left while busy", 64'(out_count - snap), 64'd0);
    check(exp_q.size() == 5, "R3", "words held", 64'(exp_q.size()), 64'd5);
    link_busy = 1'b0;
    wait_drain("R3");

    // R6: link lost mid-packet
    cur_req = "R6";
    fork
      send_pkt(5, 0, 16'h31, st);
      begin
        @(posedge clk); @(posedge clk); #2 link_busy = 1'b1;
        repeat (4) step();
        link_busy = 1'b0;
      end
    join
    check(st == 0, "R6", "input stalls during spill", 64'(st), 64'd0);
    wait_drain("R6");

    // R5: store-and-forward with free link
    cur_req = "R5"; fwd_saf = 1'b1; saf_eop_seen = 1'b0; saf_watch = 1'b1;
    snap = out_count;
    send_pkt(4, 1, 16'h41, st);
    check(out_count == snap, "R5", "words out before end word", 64'(out_count - snap), 64'd0);
    wait_drain("R5");
    saf_watch = 1'b0;
    send_pkt(1, 0, 16'h42, st);
    wait_drain("R5");
    fwd_saf = 1'b0;

    // R7: admission needs room for a full packet
    cur_req = "R7"; link_busy = 1'b1;
    send_pkt(5, 0, 16'h51, st);
    check(st == 0, "R7", "first packet stalls", 64'(st), 64'd0);
    send_pkt(5, 0, 16'h52, st);
    check(st == 0, "R7", "second packet stalls", 64'(st), 64'd0);
    fork
      send_pkt(2, 0, 16'h53, st);
      begin
        repeat (3) @(negedge clk);
        check(in_valid && !in_ready, "R7", "head refused without room",
              64'(in_ready), 64'd0);
        step();
        link_busy = 1'b0;
      end
    join
    check(st >= 3, "R7", "head stall cycles", 64'(st), 64'd3);
    wait_drain("R7");

    // R8: new head behind buffered words
    cur_req = "R8"; link_busy = 1'b1;
    send_pkt(3, 0, 16'h61, st);
    link_busy = 1'b0;
    @(negedge clk);
    check(out_valid && out_sop && out_data[31:16] == 16'h61, "R8",
          "older packet first", 64'(out_data), 64'h0061_00C4);
    step();
    send_pkt(3, 0, 16'h62, st);
    wait_drain("R8");

    // R9: backpressure, mixed lengths, single-word packets
    cur_req = "R9"; bp_en = 1'b1;
    for (int k = 1; k <= 5; k++) send_pkt(k, k % 2, 16'h70 + k, st);
    send_pkt(1, 0, 16'h7F, st);
    wait_drain("R9");
    bp_en = 1'b0; out_ready = 1'b1;
    repeat (3) step();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule